// File: doc/BRIEF.md
# Address-Matched Port Selection Controller

This block decides when one parallel FIFO-side port, either transmit or receive, may carry data. A bus master selects the port in two steps. It first drives an active-low address-match strobe. On a later clock edge it drives the transfer enable. Once the port is selected, the block turns on the output enable of the data bus. The output enable of the FIFO status flags does not depend on selection. It simply follows the address-match strobe.

A second, continuous way to select the port skips the two-step sequence. If both strobes are already asserted on a clock edge where reset is held, the port comes out of reset selected and stays selected for as long as both strobes stay asserted. While the port is in this mode, a lock output tells the neighbouring logic to refuse FIFO clear requests and serial address register accesses. A timing-mode input sets the polarity of the enable strobe. The address-match strobe is always active low.

Top module: `addr_sel_ctrl`

## Requirements
- R1: Outside continuous mode, the port becomes selected only at an edge where enable is asserted after address-match was sampled asserted on an earlier edge. Address-match does not have to stay asserted after that first edge. On the first edge that sees both strobes together, the port is only armed, and `sel_o` stays low.
- R2: A selected port that samples both strobes deasserted on the same edge becomes deselected. Enable alone cannot select it again; a new address-match is needed first.
- R3: A selected port that samples only one of the two strobes deasserted stays selected.
- R4: `bus_oe_o` is high exactly when `sel_o` is high, so the data bus is high-impedance whenever the port is not selected.
- R5: `flag_oe_o` equals the address-match state sampled at the previous edge (1 means `match_n` was 0). It is 0 after any edge where reset was sampled low.
- R6: If an edge samples `rst_n` = 0 with both strobes asserted, continuous mode is entered: `sel_o` = 1 and `cont_lock_o` = 1 right after that edge.
- R7: Continuous mode persists while both strobes are sampled asserted. It ends at the first edge where either strobe is deasserted. After that edge the port is armed if address-match was still asserted, and idle otherwise, and the normal handshake applies.
- R8: `cont_lock_o` is 1 only while continuous mode is active. A port selected through the handshake keeps it at 0.
- R9: With `en_active_high` = 0, enable is asserted when `en_n` = 0. With `en_active_high` = 1, enable is asserted when `en_n` = 1.
- R10: An edge that samples `rst_n` = 0 without both strobes asserted leaves `sel_o`, `bus_oe_o` and `cont_lock_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| match_n | input | 1 | Address-match strobe, active low |
| en_n | input | 1 | Transfer enable strobe; polarity set by `en_active_high` |
| en_active_high | input | 1 | 0: enable is active low; 1: enable is active high |
| sel_o | output | 1 | Port selected |
| bus_oe_o | output | 1 | Data-bus output enable |
| flag_oe_o | output | 1 | FIFO status flag output enable |
| cont_lock_o | output | 1 | Continuous mode active; blocks FIFO clears and address register access |

## Verification
The assertions assume that the strobes are settled at every rising edge. They also assume that `en_active_high` is held steady during a handshake, because a change of polarity in the middle reinterprets the enable level as seen by the FSM. The bench therefore changes every input just after an edge and changes polarity only while reset is held. This keeps each sampled value unambiguous, so every expected output can be worked out from the strobe sequence alone.

// File: rtl/addr_sel_pkg.sv
// Shared types of the address-matched selection controller.
package addr_sel_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,  // not selected, no address match seen yet
        ST_ARMED = 2'd1,  // address match seen, waiting for enable
        ST_SEL   = 2'd2,  // selected through the handshake
        ST_CONT  = 2'd3   // selected continuously since reset
    } sel_state_t;
endpackage

// File: rtl/strobe_norm.sv
// Turns the raw strobes into active-high "asserted" levels.
// Assumes: en_active_high is held steady during a handshake.
module strobe_norm (
    input  logic match_n,
    input  logic en_n,
    input  logic en_active_high,
    output logic match_act,
    output logic en_act
);
    // Polarity handling for both strobes.
    always_comb begin
        match_act = ~match_n;
        en_act    = en_active_high ? en_n : ~en_n;
    end
endmodule

// File: rtl/select_fsm.sv
// Selection state machine: two-step handshake plus a continuous mode
// that is latched on a reset edge. Assumes inputs are settled at the edge.
module select_fsm
    import addr_sel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match_act,
    input  logic en_act,
    output logic sel,
    output logic cont
);
    sel_state_t state_q, state_d;

    // Next-state decision for one sampled edge.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (match_act) state_d = ST_ARMED;
            ST_ARMED: if (en_act) state_d = ST_SEL;
            ST_SEL:   if (!match_act && !en_act) state_d = ST_IDLE;
            ST_CONT:  if (!(match_act && en_act))
                          state_d = match_act ? ST_ARMED : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register; a reset edge with both strobes asserted enters continuous mode.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= (match_act && en_act) ? ST_CONT : ST_IDLE;
        else        state_q <= state_d;
    end

    // Decoded outputs of the registered state.
    always_comb begin
        sel  = (state_q == ST_SEL) || (state_q == ST_CONT);
        cont = (state_q == ST_CONT);
    end

    // R1
    idle_no_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (state_q != ST_SEL));
    // R2
    both_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEL && !match_act && !en_act) |=> (state_q == ST_IDLE));
    // R3
    one_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEL && (match_act || en_act)) |=> sel);
    // R7
    cont_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cont && match_act && en_act) |=> cont);
    // R7
    cont_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cont && !(match_act && en_act)) |=> !cont);
endmodule

// File: rtl/flag_gate.sv
// Registers the FIFO flag output enable from the address-match strobe.
// Assumes: a reset edge clears it regardless of the strobe.
module flag_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic match_act,
    output logic flag_oe
);
    // Flag drivers follow the sampled address match.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_oe <= 1'b0;
        else        flag_oe <= match_act;
    end

    // R5
    flag_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_act |=> flag_oe);
    // R5
    flag_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !match_act |=> !flag_oe);
endmodule

// File: rtl/addr_sel_ctrl.sv
// Top of the address-matched port selection controller. It joins the
// strobe decoding, the selection FSM and the flag enable register.
module addr_sel_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic match_n,
    input  logic en_n,
    input  logic en_active_high,
    output logic sel_o,
    output logic bus_oe_o,
    output logic flag_oe_o,
    output logic cont_lock_o
);
    logic match_act, en_act, sel, cont;

    strobe_norm u_norm (
        .match_n(match_n), .en_n(en_n), .en_active_high(en_active_high),
        .match_act(match_act), .en_act(en_act)
    );

    select_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .match_act(match_act), .en_act(en_act),
        .sel(sel), .cont(cont)
    );

    flag_gate u_flag (
        .clk(clk), .rst_n(rst_n), .match_act(match_act), .flag_oe(flag_oe_o)
    );

    // Output drive: the data bus is driven only while selected.
    always_comb begin
        sel_o       = sel;
        bus_oe_o    = sel;
        cont_lock_o = cont;
    end

    // R8
    lock_implies_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cont_lock_o |-> sel_o);
endmodule

// File: tb/test_addr_sel_ctrl.sv
module test_addr_sel_ctrl;
    logic clk = 0, rst_n = 0, match_n = 1, en_n = 1, en_active_high = 0;
    logic sel_o, bus_oe_o, flag_oe_o, cont_lock_o;
    int checks = 0, errors = 0;

    addr_sel_ctrl i_addr_sel_ctrl (
        .clk(clk), .rst_n(rst_n), .match_n(match_n), .en_n(en_n),
        .en_active_high(en_active_high), .sel_o(sel_o), .bus_oe_o(bus_oe_o),
        .flag_oe_o(flag_oe_o), .cont_lock_o(cont_lock_o)
    );

    always #5 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic m, input logic e);
        match_n = m;
        en_n = e;
    endtask

    task automatic do_reset(input logic m, input logic e);
        rst_n = 0; drive(m, e); tick(); rst_n = 1;
    endtask

    task automatic t_reset();
        do_reset(1, 1);
        chk("R10", "sel", sel_o, 0);
        chk("R10", "bus_oe", bus_oe_o, 0);
        chk("R10", "lock", cont_lock_o, 0);
        chk("R5", "flag after reset", flag_oe_o, 0);
    endtask

    task automatic t_handshake();
        do_reset(1, 1);
        drive(0, 0); tick();
        chk("R1", "sel on first joint edge", sel_o, 0);
        chk("R5", "flag follows match", flag_oe_o, 1);
        tick();
        chk("R1", "sel after second edge", sel_o, 1);
        chk("R4", "bus_oe with sel", bus_oe_o, 1);
        chk("R8", "no lock in handshake", cont_lock_o, 0);
    endtask

    task automatic t_partial();
        drive(1, 0); tick();
        chk("R3", "match dropped only", sel_o, 1);
        chk("R5", "flag off", flag_oe_o, 0);
        drive(0, 1); tick();
        chk("R3", "enable dropped only", sel_o, 1);
    endtask

    task automatic t_deselect();
        drive(1, 1); tick();
        chk("R2", "both dropped", sel_o, 0);
        chk("R4", "bus_oe off", bus_oe_o, 0);
        drive(1, 0); tick(); tick();
        chk("R2", "enable alone", sel_o, 0);
        drive(0, 0); tick();
        chk("R2", "rearmed only", sel_o, 0);
        tick();
        chk("R2", "reselected", sel_o, 1);
    endtask

    task automatic t_match_then_en();
        do_reset(1, 1);
        drive(0, 1); tick();
        chk("R1", "armed", sel_o, 0);
        drive(1, 0); tick();
        chk("R1", "enable after released match", sel_o, 1);
    endtask

    task automatic t_cont();
        do_reset(0, 0);
        chk("R6", "sel at reset", sel_o, 1);
        chk("R6", "lock at reset", cont_lock_o, 1);
        chk("R4", "bus_oe in cont", bus_oe_o, 1);
        chk("R5", "flag cleared by reset", flag_oe_o, 0);
        tick(); tick(); tick();
        chk("R7", "cont held", cont_lock_o, 1);
        chk("R7", "sel held", sel_o, 1);
        chk("R5", "flag driven", flag_oe_o, 1);
        drive(0, 1); tick();
        chk("R7", "cont ends on enable drop", cont_lock_o, 0);
        chk("R7", "deselected", sel_o, 0);
        drive(0, 0); tick();
        chk("R7", "armed after exit", sel_o, 1);
        chk("R8", "no lock after handshake", cont_lock_o, 0);
        do_reset(0, 0);
        drive(1, 0); tick();
        chk("R7", "cont ends on match drop", cont_lock_o, 0);
        tick();
        chk("R7", "idle after exit", sel_o, 0);
    endtask

    task automatic t_polarity();
        en_active_high = 1;
        do_reset(1, 0);
        chk("R9", "low en not asserted", sel_o, 0);
        drive(0, 1); tick(); tick();
        chk("R9", "high en selects", sel_o, 1);
        drive(1, 0); tick();
        chk("R9", "low en deasserted", sel_o, 0);
        en_active_high = 0;
        do_reset(1, 1);
    endtask

    initial begin
        #(200000 * 10);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick();
        t_reset();
        t_handshake();
        t_partial();
        t_deselect();
        t_match_then_en();
        t_cont();
        t_polarity();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule